// File: doc/BRIEF.md
# Serial-Parallel Signed Multiplier

This block multiplies a two's-complement operand that arrives one bit per clock, least significant bit first, by a two's-complement coefficient presented as a parallel word. The full-precision product leaves the block as a serial stream, also least significant bit first. Each product bit appears one clock after the input bit of the same weight.

The coefficient sets one partial-product bit per stage, formed by ANDing that coefficient bit with the current serial bit. The stages for the lower coefficient bits are bit-serial adders. Each adder keeps its own carry and passes its registered sum down to the stage below. The coefficient's sign bit has negative weight, so its stage is a serial negator instead of an adder. A one-clock pulse on `init_i` marks the first bit of every word. During that clock, every carry, every inter-stage sum and the negator's detect flag are treated as zero. Words can therefore follow each other with no idle cycles.

The serial word is as long as the product, which is the operand width plus the coefficient width. The source sign-extends the operand to that length. The coefficient must be held steady for the whole word.

Top module: `spm_mult`

## Requirements
- R1: While reset is asserted and after it is released with no word sent, `prod_o` is 0.
- R2: A word starts in the clock where `init_i` is 1. The product bit of weight k is on `prod_o` one clock after data bit k was sampled, so the 16-bit product is fully out 16 clocks after its first bit.
- R3: For an 8-bit operand sent as 16 bits (bits 8 to 15 repeat bit 7) and an 8-bit coefficient, the 16 output bits equal the exact signed product X*C in two's complement.
- R4: Negative coefficients, including -128 and -127, give the correct signed product for both operand signs.
- R5: Whatever earlier words or idle cycles left in the carries, sums and negation flag, a word that starts with `init_i` gives the correct product. This holds with or without a gap and after a negative coefficient.
- R6: The first product bit equals data bit 0 ANDed with coefficient bit 0.
- R7: A zero coefficient gives an all-zero product for any operand.
- R8: The extreme products are exact: -128*-128 = 16384, -128*127 = -16256 and 127*127 = 16129.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | High during the first (LSB) bit of a word |
| data_i | input | 1 | Serial operand bit, LSB first, sign-extended |
| coef_i | input | COEF_W | Two's-complement coefficient, held for the whole word |
| prod_o | output | 1 | Serial product bit, LSB first, one clock after the input bit |

## Verification
The bench builds the block with an 8-bit coefficient and drives 8-bit operands as 16-bit serial words. At that width the product exactly fills the word. The extreme case -128*-128 therefore sets bit 14 while leaving the sign bit clear, and all bits above the operand width come from sign extension. A grid of edge operands crossed with edge coefficients covers every sign combination. Random words follow, some back to back and some after gaps filled with garbage data. These show that the start pulse alone clears the state left over from earlier words.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int unsigned COEF_W_DEF = 8;

  typedef struct packed {
    logic sum;
    logic carry;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic a, input logic b, input logic c);
    fa_out_t r;
    r.sum   = a ^ b ^ c;
    r.carry = (a & b) | (a & c) | (b & c);
    return r;
  endfunction
endpackage

// File: rtl/spm_neg_stage.sv
// Serial negator for the coefficient sign-bit term.
module spm_neg_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic in_i,
  output logic out_o
);
  logic seen_q, seen_eff;
  logic out_q;

  assign seen_eff = seen_q & ~init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      seen_q <= seen_eff | in_i;
      out_q  <= in_i ^ seen_eff;
    end
  end

  assign out_o = out_q;

  // first bit of a word passes unchanged
  assert_first_bit_copied_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> out_o == $past(in_i));

  // a zero first bit leaves the flag clear, regardless of the previous word
  assert_flag_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !in_i) |=> !seen_q);
endmodule

// File: rtl/spm_add_stage.sv
// Bit-serial adder stage; upper sum and carry are gated off during init.
module spm_add_stage
  import spm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic pp_i,
  input  logic sum_i,
  output logic sum_o
);
  logic    carry_q, sum_q;
  logic    carry_eff, upper_eff;
  fa_out_t fa;

  assign carry_eff = carry_q & ~init_i;
  assign upper_eff = sum_i & ~init_i;
  assign fa        = full_add(pp_i, upper_eff, carry_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      sum_q   <= 1'b0;
    end else begin
      carry_q <= fa.carry;
      sum_q   <= fa.sum;
    end
  end

  assign sum_o = sum_q;

  assert_no_carry_after_init_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !carry_q);

  assert_init_sum_is_pp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> sum_o == $past(pp_i));
endmodule

// File: rtl/spm_mult.sv
module spm_mult
  import spm_pkg::*;
#(
  parameter int unsigned COEF_W = COEF_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              data_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              prod_o
);
  localparam int unsigned TOP = COEF_W - 1;

  logic [COEF_W-1:0] pp;
  logic [COEF_W-1:0] stage_sum;

  assign pp = {COEF_W{data_i}} & coef_i;

  // sign-bit term carries negative weight
  spm_neg_stage u_neg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .in_i   (pp[TOP]),
    .out_o  (stage_sum[TOP])
  );

  for (genvar i = 0; i < TOP; i++) begin : g_add
    spm_add_stage u_add (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .init_i (init_i),
      .pp_i   (pp[i]),
      .sum_i  (stage_sum[i+1]),
      .sum_o  (stage_sum[i])
    );
  end

  assign prod_o = stage_sum[0];

  assert_lsb_product_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> prod_o == $past(data_i & coef_i[0]));

  assert_zero_coef_first_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && coef_i == '0) |=> !prod_o);
endmodule

// File: tb/spm_mult_test.sv
module spm_mult_test;
  localparam int unsigned COEF_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned PROD_W = COEF_W + DATA_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              init_i = 1'b0;
  logic              data_i = 1'b0;
  logic [COEF_W-1:0] coef_i = '0;
  logic              prod_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [PROD_W-1:0] exp_q[$];
  string             tag_q[$];

  spm_mult #(.COEF_W(COEF_W)) uut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(init_i),
    .data_i(data_i),
    .coef_i(coef_i),
    .prod_o(prod_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic send_word(input int x, input int c, input string tag);
    logic [PROD_W-1:0] xe;
    int                p;
    xe = PROD_W'(x);
    p  = x * c;
    exp_q.push_back(PROD_W'(p));
    tag_q.push_back(tag);
    for (int b = 0; b < int'(PROD_W); b++) begin
      @(negedge clk_i);
      init_i = (b == 0);
      data_i = xe[b];
      coef_i = COEF_W'(c);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      init_i = 1'b0;
      data_i = 1'($urandom);
      coef_i = COEF_W'($urandom);
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic [PROD_W-1:0] acc;
    logic [PROD_W-1:0] exp;
    string             tag;
    int                cnt;
    bit                on;
    bit                samp_init;
    acc = '0;
    cnt = 0;
    on  = 0;
    forever begin
      @(posedge clk_i);
      samp_init = init_i;
      @(negedge clk_i);
      if (samp_init) begin
        on  = 1;
        cnt = 0;
      end
      if (on) begin
        acc[cnt] = prod_o;
        cnt++;
        if (cnt == int'(PROD_W)) begin
          on = 0;
          if (exp_q.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL R2: product word with no expected entry, actual %0d expected none", $signed(acc));
          end else begin
            exp = exp_q.pop_front();
            tag = tag_q.pop_front();
            checks++;
            if (acc !== exp) begin
              failures++;
              $display("FAIL %s: product actual %0d expected %0d", tag, $signed(acc), $signed(exp));
            end
            checks++;
            if (acc[0] !== exp[0]) begin
              failures++;
              $display("FAIL R6: first product bit actual %0b expected %0b", acc[0], exp[0]);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    int xs[8];
    int cs[8];
    string tag;
    xs = '{-128, -127, -1, 0, 1, 2, 85, 127};
    cs = '{-128, -127, -86, -1, 0, 1, 64, 127};

    repeat (3) @(negedge clk_i);
    checks++;
    if (prod_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: prod_o in reset actual %0b expected 0", prod_o);
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    checks++;
    if (prod_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: prod_o after reset actual %0b expected 0", prod_o);
    end

    // R8 extremes
    send_word(-128, -128, "R8");
    send_word(-128, 127, "R8");
    send_word(127, 127, "R8");
    send_word(127, -128, "R8");

    // grid of sign combinations, back to back
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        if (cs[j] == 0) tag = "R7";
        else if (cs[j] < 0) tag = "R4";
        else tag = "R3";
        send_word(xs[i], cs[j], tag);
      end
    end

    // random words, some after garbage gaps
    for (int n = 0; n < 300; n++) begin
      int x;
      int c;
      int gap;
      x   = int'($signed(8'($urandom)));
      c   = int'($signed(8'($urandom)));
      gap = int'($urandom % 4);
      if (gap > 0) begin
        idle(gap);
        send_word(x, c, "R5");
      end else begin
        send_word(x, c, "R2");
      end
    end

    @(negedge clk_i);
    init_i = 1'b0;
    data_i = 1'b0;
    repeat (PROD_W + 4) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2: products not seen actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule